// File: doc/BRIEF.md
# B3ZS/HDB3 Bipolar Line Decoder

This block sits directly behind the line receiver of a DS3 or E3 port. Each line clock it samples two rails, one carrying positive marks and one carrying negative marks, and turns the bipolar stream into a single unipolar data bit. In DS3 mode it finds three-symbol zero substitutions and restores the zeros. In E3 mode it does the same for four-symbol substitutions. A pass-through control turns off substitution removal so that plain alternate-mark-inversion traffic can be received.

Alongside the data, the block watches the line for coding errors and counts them in a saturating counter. What counts as an error depends on the mode. DS3 mode counts stray polarity violations, substitutions of the wrong kind for the current mark parity, and long zero runs. E3 mode counts only violations whose polarity repeats the previous violation's polarity. Software reads the counter by sampling it in the same cycle that it pulses the read strobe. The counter then restarts, so no error is lost.

Decoding works through a fixed look-ahead window, so the data latency is constant for each mode. The mode and pass-through controls are meant to be static while traffic flows.

Top module: `b3zs_hdb3_decoder`

## Requirements
- R1: With `e3_mode_i`=0 and `ami_i`=0, each pattern of a zero, a zero and a violation, or of a mark, a zero and a violation, is output as three zeros. Here a violation is a mark with the same polarity as the previous polar mark. A line symbol sampled at rising edge n shows up on `data_o` just after edge n+2, where a zero symbol gives 0 and any mark gives 1.
- R2: With `e3_mode_i`=1 and `ami_i`=0, the patterns zero-zero-zero-violation and mark-zero-zero-violation are output as four zeros, and the data latency is one edge longer than in R1 (edge n+3).
- R3: A correct substitution adds nothing to `cnt_o`. In DS3 this means the substitution type agrees with the mark parity. In E3 it means the violation's polarity is opposite to that of the previous violation.
- R4: DS3 mark parity is the number of polar marks since the last removed substitution, modulo 2. An odd count before the substitution calls for zero-zero-violation, and an even count calls for mark-zero-violation. A substitution of the other type is still output as three zeros, but it adds one to the count.
- R5: In DS3 mode, a violation that does not follow a zero is not a substitution. Its data bit is output as 1 and it adds one to the count.
- R6: In DS3 mode, each run of three or more consecutive zero symbols adds exactly one to the count, at its third zero.
- R7: In E3 mode, a violation adds one only when its polarity equals the polarity of the previous violation. Zero runs of any length, and violations with alternating polarity, add nothing.
- R8: With `ami_i`=1, no symbol is zeroed. Every violation adds one, zero runs add nothing, and the latency follows the mode as in R1 and R2.
- R9: A sample with both rails high is output as a 1. It does not change the polarity history, never counts, and never forms part of a substitution.
- R10: `cnt_o` holds its value until an event or a read. In a cycle with `rd_i`=1, the value on `cnt_o` is the value read, and after that edge the counter is 0 if no event coincided.
- R11: If a read and an event fall on the same edge, the counter becomes 1.
- R12: The counter rises by one per event and saturates at 0xFFFF.
- R13: Reset (active low, asynchronous) clears `data_o` and `cnt_o` and forgets the polarity history, so the first polar mark after reset is never a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_i | input | 1 | Positive-mark rail (pos=1, neg=0 is a positive mark) |
| neg_i | input | 1 | Negative-mark rail (pos=0, neg=1 is a negative mark) |
| e3_mode_i | input | 1 | 0 selects DS3 three-symbol decoding, 1 selects E3 four-symbol decoding |
| ami_i | input | 1 | 1 disables substitution removal |
| rd_i | input | 1 | Counter read strobe; clears the counter after this edge |
| data_o | output | 1 | Decoded unipolar data |
| cnt_o | output | CNT_W | Violation counter value |

## Verification
Two functions can land on the same edge: a read strobe and an error event. The bench provokes this by raising `rd_i` in the same cycle that it drives a repeated-polarity mark. It does this once at a low count and once after driving a long run of same-polarity marks that saturates the counter. In both cases the counter must hold 1 afterwards, not 0 and not the previous value plus one. The main sweep feeds every byte value through a bench-side encoder in both modes and requires the decoded bits at the mode's latency, with a zero count.

// File: rtl/b3_line_pkg.sv
`timescale 1ns/1ps
package b3_line_pkg;

   // Rail pair {neg, pos}
   typedef enum logic [1:0] {
      LS_SPACE = 2'b00,
      LS_POS   = 2'b01,
      LS_NEG   = 2'b10,
      LS_DUAL  = 2'b11
   } line_sym_e;

   // Substitution length per line code; also the data latency in edges
   localparam int unsigned DS3_SPAN = 3;
   localparam int unsigned E3_SPAN  = 4;
   // Raw symbols kept behind the current one for shape matching
   localparam int unsigned HIST_LEN = E3_SPAN - 1;

   function automatic logic sym_polar(input line_sym_e s);
      return (s == LS_POS) || (s == LS_NEG);
   endfunction

endpackage

// File: rtl/b3_rail_sampler.sv
`timescale 1ns/1ps
module b3_rail_sampler
   import b3_line_pkg::*;
#(
   parameter int unsigned HIST = HIST_LEN
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pos_i,
   input  logic      neg_i,
   output line_sym_e cur_sym_o,
   output line_sym_e hist_o [HIST]
);

   line_sym_e hist_q [HIST];
   line_sym_e hist_d [HIST];

   assign cur_sym_o = line_sym_e'({neg_i, pos_i});

   for (genvar g = 0; g < HIST; g++) begin : g_tap
      if (g == 0) begin : g_head
         assign hist_d[g] = cur_sym_o;
      end else begin : g_body
         assign hist_d[g] = hist_q[g-1];
      end
      assign hist_o[g] = hist_q[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < HIST; i++) hist_q[i] <= LS_SPACE;
      end else begin
         for (int i = 0; i < HIST; i++) hist_q[i] <= hist_d[i];
      end
   end

endmodule

// File: rtl/b3_viol_engine.sv
`timescale 1ns/1ps
module b3_viol_engine
   import b3_line_pkg::*;
#(
   parameter int unsigned ZRUN_LIM = 3,
   parameter int unsigned HIST     = HIST_LEN
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      e3_i,
   input  logic      ami_i,
   input  line_sym_e cur_sym_i,
   input  line_sym_e hist_i [HIST],
   output logic      kill_o,
   output logic      inc_o
);

   localparam int unsigned ZW        = $clog2(ZRUN_LIM + 1);
   localparam logic [ZW-1:0] ZRUN_TOP  = ZW'(ZRUN_LIM);
   localparam logic [ZW-1:0] ZRUN_EDGE = ZW'(ZRUN_LIM - 1);

   if (HIST < 3) begin : g_bad_hist
      $error("b3_viol_engine: history must hold at least three symbols");
   end

   logic          pol_vld_q, last_neg_q, odd_q;
   logic          vio_vld_q, vio_neg_q;
   logic [ZW-1:0] zrun_q;

   logic cur_polar, cur_neg, cur_space;
   logic bpv, ds3_shape, e3_shape, sig, zrun_hit;
   logic inc_ds3, inc_e3;

   always_comb begin
      cur_polar = sym_polar(cur_sym_i);
      cur_neg   = (cur_sym_i == LS_NEG);
      cur_space = (cur_sym_i == LS_SPACE);
      // repeated polarity against the last polar mark
      bpv       = cur_polar && pol_vld_q && (cur_neg == last_neg_q);
      // zero-zero-V or mark-zero-V
      ds3_shape = (hist_i[0] == LS_SPACE) &&
                  ((hist_i[1] == LS_SPACE) || sym_polar(hist_i[1]));
      // zero-zero-zero-V or mark-zero-zero-V
      e3_shape  = (hist_i[0] == LS_SPACE) && (hist_i[1] == LS_SPACE) &&
                  ((hist_i[2] == LS_SPACE) || sym_polar(hist_i[2]));
      sig       = !ami_i && bpv && (e3_i ? e3_shape : ds3_shape);
      zrun_hit  = cur_space && (zrun_q == ZRUN_EDGE);
      // odd_q already includes a leading mark, so a correct type of either
      // form always meets an odd parity here
      inc_ds3   = (bpv && !sig) || (sig && !odd_q) || zrun_hit;
      inc_e3    = bpv && vio_vld_q && (cur_neg == vio_neg_q);
      if (ami_i)     inc_o = bpv;
      else if (e3_i) inc_o = inc_e3;
      else           inc_o = inc_ds3;
   end

   assign kill_o = sig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_vld_q  <= 1'b0;
         last_neg_q <= 1'b0;
         odd_q      <= 1'b0;
         vio_vld_q  <= 1'b0;
         vio_neg_q  <= 1'b0;
         zrun_q     <= '0;
      end else begin
         if (cur_polar) begin
            pol_vld_q  <= 1'b1;
            last_neg_q <= cur_neg;
         end
         if (sig)            odd_q <= 1'b0;
         else if (cur_polar) odd_q <= ~odd_q;
         if (!cur_space)               zrun_q <= '0;
         else if (zrun_q != ZRUN_TOP)  zrun_q <= zrun_q + 1'b1;
         if (bpv) begin
            vio_vld_q <= 1'b1;
            vio_neg_q <= cur_neg;
         end
      end
   end

endmodule

// File: rtl/b3_mark_window.sv
`timescale 1ns/1ps
module b3_mark_window #(
   parameter int unsigned DS3_TAP = 3,
   parameter int unsigned E3_TAP  = 4
)(
   input  logic clk,
   input  logic rst_n,
   input  logic mark_i,
   input  logic kill_i,
   input  logic e3_i,
   output logic data_o
);

   localparam int unsigned DEPTH = (E3_TAP > DS3_TAP) ? E3_TAP : DS3_TAP;

   if (DS3_TAP < 2 || E3_TAP < 2) begin : g_bad_tap
      $error("b3_mark_window: taps must be at least two");
   end

   logic [DEPTH-1:0] win_q;
   logic [DEPTH-1:0] win_d;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic clr;
      logic nxt;
      if (g < DS3_TAP && g < E3_TAP) begin : g_any
         assign clr = kill_i;
      end else if (g < E3_TAP) begin : g_e3
         assign clr = kill_i && e3_i;
      end else begin : g_ds3
         assign clr = kill_i && !e3_i;
      end
      if (g == 0) begin : g_in
         assign nxt = mark_i;
      end else begin : g_sh
         assign nxt = win_q[g-1];
      end
      assign win_d[g] = clr ? 1'b0 : nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= '0;
      else        win_q <= win_d;
   end

   assign data_o = e3_i ? win_q[E3_TAP-1] : win_q[DS3_TAP-1];

endmodule

// File: rtl/b3_sat_counter.sv
`timescale 1ns/1ps
module b3_sat_counter #(
   parameter int unsigned W = 16
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         rd_i,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] TOP = '1;

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (rd_i)                   cnt_q <= {{(W-1){1'b0}}, inc_i};
      else if (inc_i && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/b3zs_hdb3_decoder.sv
`timescale 1ns/1ps
module b3zs_hdb3_decoder
   import b3_line_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned ZRUN_LIM = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pos_i,
   input  logic             neg_i,
   input  logic             e3_mode_i,
   input  logic             ami_i,
   input  logic             rd_i,
   output logic             data_o,
   output logic [CNT_W-1:0] cnt_o
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("b3zs_hdb3_decoder: counter width too small");
   end
   if (ZRUN_LIM < 2) begin : g_bad_zrun
      $error("b3zs_hdb3_decoder: zero-run limit must be at least two");
   end

   line_sym_e cur_sym;
   line_sym_e hist [HIST_LEN];
   logic      sig_kill;
   logic      cnt_inc;
   logic      line_mark;

   assign line_mark = (cur_sym != LS_SPACE);

   b3_rail_sampler #(.HIST(HIST_LEN)) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .pos_i     (pos_i),
      .neg_i     (neg_i),
      .cur_sym_o (cur_sym),
      .hist_o    (hist)
   );

   b3_viol_engine #(.ZRUN_LIM(ZRUN_LIM), .HIST(HIST_LEN)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .e3_i      (e3_mode_i),
      .ami_i     (ami_i),
      .cur_sym_i (cur_sym),
      .hist_i    (hist),
      .kill_o    (sig_kill),
      .inc_o     (cnt_inc)
   );

   b3_mark_window #(.DS3_TAP(DS3_SPAN), .E3_TAP(E3_SPAN)) u_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .mark_i (line_mark),
      .kill_i (sig_kill),
      .e3_i   (e3_mode_i),
      .data_o (data_o)
   );

   b3_sat_counter #(.W(CNT_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (cnt_inc),
      .rd_i  (rd_i),
      .cnt_o (cnt_o)
   );

endmodule

// File: rtl/b3_decoder_checker.sv
`timescale 1ns/1ps
module b3_decoder_checker #(
   parameter int unsigned CNT_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             pos_i,
   input logic             neg_i,
   input logic             e3_mode_i,
   input logic             ami_i,
   input logic             rd_i,
   input logic             inc,
   input logic             kill,
   input logic             data_o,
   input logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] TOP = '1;

   assert_reset_R13: assert property (@(posedge clk)
      !rst_n |=> (cnt_o == '0) && !data_o);

   assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i && !inc |=> cnt_o == '0);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i && !inc |=> $stable(cnt_o));

   assert_rd_inc_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i && inc |=> cnt_o == CNT_W'(1));

   assert_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i && inc && cnt_o != TOP |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

   assert_no_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i && cnt_o == TOP |=> cnt_o == TOP);

   assert_ami_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ami_i |-> !kill);

   assert_dual_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pos_i && neg_i |-> !inc && !kill);

   assert_e3_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
      e3_mode_i && !ami_i && !pos_i && !neg_i |-> !inc);

endmodule

bind b3zs_hdb3_decoder b3_decoder_checker #(.CNT_W(CNT_W)) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .pos_i     (pos_i),
   .neg_i     (neg_i),
   .e3_mode_i (e3_mode_i),
   .ami_i     (ami_i),
   .rd_i      (rd_i),
   .inc       (cnt_inc),
   .kill      (sig_kill),
   .data_o    (data_o),
   .cnt_o     (cnt_o)
);

// File: tb/tb_b3zs_hdb3_decoder.sv
`timescale 1ns/1ps
module tb_b3zs_hdb3_decoder;

   localparam logic [1:0] S0 = 2'b00;  // space
   localparam logic [1:0] SP = 2'b01;  // positive mark
   localparam logic [1:0] SN = 2'b10;  // negative mark
   localparam logic [1:0] SB = 2'b11;  // both rails high

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pos_i = 1'b0;
   logic        neg_i = 1'b0;
   logic        e3_mode_i = 1'b0;
   logic        ami_i = 1'b0;
   logic        rd_i = 1'b0;
   logic        data_o;
   logic [15:0] cnt_o;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   b3zs_hdb3_decoder dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pos_i     (pos_i),
      .neg_i     (neg_i),
      .e3_mode_i (e3_mode_i),
      .ami_i     (ami_i),
      .rd_i      (rd_i),
      .data_o    (data_o),
      .cnt_o     (cnt_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic drive(input logic [1:0] s, input logic r = 1'b0);
      pos_i = s[0];
      neg_i = s[1];
      rd_i  = r;
      @(negedge clk);
   endtask

   task automatic restart(input logic e3, input logic ami);
      rst_n = 1'b0;
      pos_i = 1'b0;
      neg_i = 1'b0;
      rd_i  = 1'b0;
      e3_mode_i = e3;
      ami_i = ami;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // encode every byte value with the mode's substitution rule, then decode
   task automatic run_encoded(input logic e3);
      bit         dq[$];
      logic [1:0] sq[$];
      int         span;
      logic       lneg;
      bit         par;
      int         i;
      string      tag;
      span = e3 ? 4 : 3;
      lneg = 1'b1;
      par  = 1'b0;
      i    = 0;
      tag  = e3 ? "R2 four-zero decode" : "R1 three-zero decode";
      dq.push_back(1'b1);
      for (int b = 0; b < 256; b++)
         for (int j = 0; j < 8; j++) dq.push_back(b[j]);
      repeat (4) dq.push_back(1'b1);
      while (i < dq.size()) begin
         bit run;
         run = (i + span <= dq.size());
         for (int j = 0; j < span; j++)
            if (run && dq[i+j]) run = 1'b0;
         if (run) begin
            if (par) begin
               repeat (span - 1) sq.push_back(S0);
               sq.push_back(lneg ? SN : SP);
            end else begin
               lneg = ~lneg;
               sq.push_back(lneg ? SN : SP);
               repeat (span - 2) sq.push_back(S0);
               sq.push_back(lneg ? SN : SP);
            end
            par = 1'b0;
            i += span;
         end else if (dq[i]) begin
            lneg = ~lneg;
            sq.push_back(lneg ? SN : SP);
            par = ~par;
            i++;
         end else begin
            sq.push_back(S0);
            i++;
         end
      end
      restart(e3, 1'b0);
      for (int k = 0; k < sq.size(); k++) begin
         drive(sq[k]);
         if (k >= span - 1) check(tag, data_o, dq[k-span+1]);
      end
      check("R3 valid substitutions uncounted", cnt_o, 0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      restart(1'b0, 1'b0);
      check("R13 reset data", data_o, 0);
      check("R13 reset count", cnt_o, 0);

      run_encoded(1'b0);
      run_encoded(1'b1);

      // R1 / R3: proper zero-zero-V after an odd mark count
      restart(1'b0, 1'b0);
      drive(SP); drive(S0); drive(S0); drive(SP); drive(SN);
      drive(SP);
      check("R1 violation removed", data_o, 0);
      drive(SN);
      check("R1 following mark", data_o, 1);
      check("R3 proper DS3 uncounted", cnt_o, 0);

      // R4: mark-zero-V after an odd count is the wrong type
      restart(1'b0, 1'b0);
      drive(SP); drive(SN); drive(S0); drive(SN);
      check("R4 leading mark zeroed", data_o, 0);
      drive(SP); drive(SN);
      check("R4 violation zeroed", data_o, 0);
      check("R4 wrong type counted", cnt_o, 1);

      // R5: violation directly after a mark
      restart(1'b0, 1'b0);
      drive(SP); drive(SP); drive(SN); drive(SP);
      check("R5 stray violation kept", data_o, 1);
      check("R5 stray violation counted", cnt_o, 1);

      // R10: read returns value then clears
      check("R10 value before read", cnt_o, 1);
      drive(SN, 1'b1);
      check("R10 cleared after read", cnt_o, 0);
      // R11: read coincides with a repeated-polarity mark
      drive(SN, 1'b1);
      check("R11 read with event", cnt_o, 1);
      drive(SP);
      check("R10 holds without event", cnt_o, 1);

      // R6: long zero runs in DS3
      restart(1'b0, 1'b0);
      drive(SP);
      repeat (5) drive(S0);
      drive(SN);
      check("R6 five zeros counted once", cnt_o, 1);
      drive(S0); drive(S0); drive(SP);
      check("R6 two zeros not counted", cnt_o, 1);
      drive(S0); drive(S0); drive(S0);
      check("R6 three zeros counted", cnt_o, 2);

      // R7: E3 counting
      restart(1'b1, 1'b0);
      drive(SP);
      repeat (6) drive(S0);
      drive(SN);
      check("R7 zero run ignored", cnt_o, 0);
      drive(SP); drive(SP); drive(SP);
      check("R7 same-polarity pair counted", cnt_o, 1);
      drive(SN); drive(SN);
      check("R7 alternating violation ignored", cnt_o, 1);

      // R8: pass-through mode
      restart(1'b0, 1'b1);
      drive(SP); drive(S0); drive(S0); drive(SP); drive(SN); drive(SP);
      check("R8 violation kept as data", data_o, 1);
      drive(S0); drive(S0); drive(S0); drive(SN);
      check("R8 violation counted, zeros not", cnt_o, 1);

      // R9: both rails high
      restart(1'b0, 1'b0);
      drive(SP); drive(SB); drive(SN); drive(SB);
      check("R9 dual sample is a one", data_o, 1);
      drive(SP);
      check("R9 mark after dual", data_o, 1);
      check("R9 dual never counted", cnt_o, 0);

      // R13: polarity history forgotten across reset
      restart(1'b0, 1'b0);
      drive(SP);
      restart(1'b0, 1'b0);
      drive(SP);
      check("R13 first mark after reset", cnt_o, 0);

      // R12: saturation, then R11 at the ceiling
      restart(1'b0, 1'b0);
      for (int k = 0; k < 65540; k++) drive(SP);
      check("R12 saturated", cnt_o, 16'hFFFF);
      drive(SP);
      check("R12 stays saturated", cnt_o, 16'hFFFF);
      drive(SP, 1'b1);
      check("R11 read with event at ceiling", cnt_o, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule